// File: doc/BRIEF.md
# Execution Lease Controller

The lease controller hands the processor to untrusted code for a bounded number of cycles and confines that code's stores to a bounded address region. A lease is granted by handing the controller a request carrying a duration, a trusted restore address and a region given as a value and a compare mask. While the lease runs, its remaining time counts down by one each cycle. When it reaches zero, the controller overrides the processor's next-PC candidate with the restore address, whatever branch or jump the untrusted code chose. The expired lease is then dropped.

Leases nest. Accepted requests are kept on a small hardware stack; only the top entry counts down and only its region gates stores. When the top expires it is popped and the enclosing lease resumes with the time it had left. Remaining time is visible on `time_left`, and any duration value may be loaded. A scheduler can therefore save a lease's remaining time and grant it again later, which lets software build schedulers of several levels.

The request port is a valid/ready stream. `req_ready` is low while the stack is full or while the top lease expires in the current cycle. A request is accepted on a cycle with both `req_valid` and `req_ready` high. An upstream that sees `req_ready` low keeps its request pending and may retry. A request offered while the stack is full raises `push_err` in that cycle and is not taken. The PC override and the store gate are combinational paths from the current state and inputs.

Top module: `lease_ctrl`

## Requirements
- R1: While a lease is active and neither expires nor is pushed over in a cycle, `time_left` (the top entry's remaining count) is one lower in the next cycle.
- R2: When a lease is active and `time_left` is 0, `redirect` is 1 and `pc_next_out` equals the top entry's restore address. In every other cycle `redirect` is 0 and `pc_next_out` equals `pc_next_in`.
- R3: An accepted request becomes the top entry and `lease_depth` rises by one. An expiry pops the top entry and `lease_depth` falls by one. An enclosing lease's count is frozen while a lease above it runs, so after the pop it resumes with the count it had when it was covered.
- R4: With no lease active (`lease_depth` 0), `st_en` equals `st_req`.
- R5: With a lease active, `st_en` is 1 only when `st_req` is 1 and `((st_addr ^ value) & mask) == 0`, where `value` and `mask` are the top entry's fields. A mask bit of 1 means the address bit is compared; a mask bit of 0 means it is ignored.
- R6: `req_ready` is 1 exactly when `lease_depth` is below DEPTH and no expiry happens in the current cycle.
- R7: A request offered while `lease_depth` equals DEPTH raises `push_err` in that cycle and leaves the stack unchanged. `push_err` is 0 in every other cycle.
- R8: A lease accepted with duration 0 expires in the very next cycle. A lease with duration D expires D+1 cycles after its acceptance if nothing is pushed above it.
- R9: After reset, `lease_depth` is 0, `time_left` is 0, `redirect` is 0 and `req_ready` is 1. `time_left` reads 0 whenever no lease is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lease request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_dur | input | TW | Lease duration in cycles |
| req_restore | input | AW | Trusted restore address for expiry |
| req_val | input | AW | Region value |
| req_mask | input | AW | Region compare mask (1 = compare) |
| pc_next_in | input | AW | Next-PC candidate from the pipeline |
| pc_next_out | output | AW | Next PC after override |
| redirect | output | 1 | Top lease expires this cycle |
| st_req | input | 1 | Store attempted |
| st_addr | input | AW | Store address |
| st_en | output | 1 | Store write enable after gating |
| push_err | output | 1 | Request offered while the stack is full |
| lease_depth | output | $clog2(DEPTH+1) | Number of leases held |
| time_left | output | TW | Remaining count of the top lease |

## Verification
The bench builds the controller with DEPTH=3, TW=8 and AW=8. A stack of three fills within a few requests, so full-stack errors and back-pressure come up often under random traffic. An 8-bit address space with sparse random masks makes region hits and misses about equally likely. Durations are mostly drawn small, so expiries, pops into enclosing leases and zero-length leases all occur many times. Occasional long durations exercise counts far from zero.

// File: rtl/lease_pkg.sv
package lease_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_TICK = 2'd3
  } stk_op_e;
endpackage

// File: rtl/lease_region_match.sv
module lease_region_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] care,
  output logic          hit
);
  // Each cared-for address bit must equal the base bit.
  assign hit = ~|((addr ^ base) & care);
endmodule

// File: rtl/lease_pc_sel.sv
module lease_pc_sel #(
  parameter int AW = 32
) (
  input  logic          force_restore,
  input  logic [AW-1:0] restore_pc,
  input  logic [AW-1:0] cand_pc,
  output logic [AW-1:0] sel_pc
);
  assign sel_pc = force_restore ? restore_pc : cand_pc;
endmodule

// File: rtl/lease_stack.sv
module lease_stack
  import lease_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TW    = 16,
  parameter int AW    = 32,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  stk_op_e        op,
  input  logic [TW-1:0]  in_dur,
  input  logic [AW-1:0]  in_restore,
  input  logic [AW-1:0]  in_val,
  input  logic [AW-1:0]  in_mask,
  output logic [TW-1:0]  top_dur,
  output logic [AW-1:0]  top_restore,
  output logic [AW-1:0]  top_val,
  output logic [AW-1:0]  top_mask,
  output logic [SPW-1:0] depth,
  output logic           full,
  output logic           empty
);
  logic [SPW-1:0] sp_q;
  logic [TW-1:0]  dur_q  [DEPTH];
  logic [AW-1:0]  rpc_q  [DEPTH];
  logic [AW-1:0]  val_q  [DEPTH];
  logic [AW-1:0]  mask_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (op == STK_PUSH) begin
      sp_q <= sp_q + 1'b1;
    end else if (op == STK_POP) begin
      sp_q <= sp_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dur_q[i]  <= '0;
        rpc_q[i]  <= '0;
        val_q[i]  <= '0;
        mask_q[i] <= '0;
      end else if (op == STK_PUSH && sp_q == SPW'(i)) begin
        dur_q[i]  <= in_dur;
        rpc_q[i]  <= in_restore;
        val_q[i]  <= in_val;
        mask_q[i] <= in_mask;
      end else if (op == STK_TICK && sp_q == SPW'(i + 1)) begin
        dur_q[i] <= dur_q[i] - 1'b1;
      end
    end
  end

  always_comb begin
    top_dur     = '0;
    top_restore = '0;
    top_val     = '0;
    top_mask    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (sp_q == SPW'(k + 1)) begin
        top_dur     = dur_q[k];
        top_restore = rpc_q[k];
        top_val     = val_q[k];
        top_mask    = mask_q[k];
      end
    end
  end

  assign depth = sp_q;
  assign full  = (sp_q == SPW'(DEPTH));
  assign empty = (sp_q == '0);
endmodule

// File: rtl/lease_ctrl.sv
module lease_ctrl
  import lease_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TW    = 16,
  parameter int AW    = 32,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [TW-1:0]  req_dur,
  input  logic [AW-1:0]  req_restore,
  input  logic [AW-1:0]  req_val,
  input  logic [AW-1:0]  req_mask,
  input  logic [AW-1:0]  pc_next_in,
  output logic [AW-1:0]  pc_next_out,
  output logic           redirect,
  input  logic           st_req,
  input  logic [AW-1:0]  st_addr,
  output logic           st_en,
  output logic           push_err,
  output logic [SPW-1:0] lease_depth,
  output logic [TW-1:0]  time_left
);
  logic [TW-1:0] top_dur;
  logic [AW-1:0] top_restore, top_val, top_mask;
  logic          full, empty, active, expire, accept, region_hit;
  stk_op_e       op;

  assign active = !empty;
  assign expire = active && (top_dur == '0);
  assign req_ready = !full && !expire;
  assign accept = req_valid && req_ready;

  // Expiry wins, then a new lease, else the top lease ages.
  always_comb begin
    if (expire)      op = STK_POP;
    else if (accept) op = STK_PUSH;
    else if (active) op = STK_TICK;
    else             op = STK_HOLD;
  end

  lease_stack #(.DEPTH(DEPTH), .TW(TW), .AW(AW)) u_stack (
    .clk(clk), .rst_n(rst_n), .op(op),
    .in_dur(req_dur), .in_restore(req_restore),
    .in_val(req_val), .in_mask(req_mask),
    .top_dur(top_dur), .top_restore(top_restore),
    .top_val(top_val), .top_mask(top_mask),
    .depth(lease_depth), .full(full), .empty(empty)
  );

  lease_region_match #(.AW(AW)) u_match (
    .addr(st_addr), .base(top_val), .care(top_mask), .hit(region_hit)
  );

  lease_pc_sel #(.AW(AW)) u_pcsel (
    .force_restore(expire), .restore_pc(top_restore),
    .cand_pc(pc_next_in), .sel_pc(pc_next_out)
  );

  assign redirect  = expire;
  assign st_en     = st_req && (!active || region_hit);
  assign push_err  = req_valid && full;
  assign time_left = top_dur;
endmodule

// File: rtl/lease_ctrl_chk.sv
module lease_ctrl_chk #(
  parameter int DEPTH = 4,
  parameter int TW    = 16,
  parameter int AW    = 32,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           redirect,
  input logic           st_req,
  input logic           st_en,
  input logic           push_err,
  input logic [AW-1:0]  st_addr,
  input logic [AW-1:0]  top_val,
  input logic [AW-1:0]  top_mask,
  input logic [SPW-1:0] lease_depth,
  input logic [TW-1:0]  time_left
);
  p_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lease_depth != '0 && !redirect && !(req_valid && req_ready))
      |=> time_left == $past(time_left) - 1'b1);

  p_expiry_pops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> lease_depth == $past(lease_depth) - 1'b1);

  p_accept_pushes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> lease_depth == $past(lease_depth) + 1'b1);

  p_free_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lease_depth == '0) |-> st_en == st_req);

  p_outside_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lease_depth != '0 && ((st_addr ^ top_val) & top_mask) != '0) |-> !st_en);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lease_depth <= SPW'(DEPTH));

  p_full_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lease_depth == SPW'(DEPTH))
      |-> (push_err && !req_ready) ##1 lease_depth == $past(lease_depth)
          - SPW'($past(redirect)));
endmodule

bind lease_ctrl lease_ctrl_chk #(.DEPTH(DEPTH), .TW(TW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .redirect(redirect), .st_req(st_req), .st_en(st_en), .push_err(push_err),
  .st_addr(st_addr), .top_val(top_val), .top_mask(top_mask),
  .lease_depth(lease_depth), .time_left(time_left)
);

// File: tb/lease_ctrl_test.sv
module lease_ctrl_test;
  localparam int DEPTH = 3;
  localparam int TW    = 8;
  localparam int AW    = 8;
  localparam int SPW   = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, st_req = 0;
  logic req_ready, redirect, st_en, push_err;
  logic [TW-1:0] req_dur = '0, time_left;
  logic [AW-1:0] req_restore = '0, req_val = '0, req_mask = '0;
  logic [AW-1:0] pc_next_in = '0, pc_next_out, st_addr = '0;
  logic [SPW-1:0] lease_depth;

  int errors = 0, checks = 0, cycles = 0;
  int msp = 0;
  logic [TW-1:0] mdur [DEPTH];
  logic [AW-1:0] mrst [DEPTH], mval [DEPTH], mmask [DEPTH];

  always #2 clk = ~clk;

  lease_ctrl #(.DEPTH(DEPTH), .TW(TW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dur(req_dur), .req_restore(req_restore), .req_val(req_val),
    .req_mask(req_mask), .pc_next_in(pc_next_in), .pc_next_out(pc_next_out),
    .redirect(redirect), .st_req(st_req), .st_addr(st_addr), .st_en(st_en),
    .push_err(push_err), .lease_depth(lease_depth), .time_left(time_left)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic f_hit(input logic [AW-1:0] a, input logic [AW-1:0] v,
                                 input logic [AW-1:0] m);
    return ((a ^ v) & m) == '0;
  endfunction

  // Called after inputs are driven at a falling edge: checks, then advances model.
  task automatic step();
    logic act, exp_exp, exp_rdy, exp_st;
    int t;
    #1;
    act = (msp > 0);
    t = act ? msp - 1 : 0;
    exp_exp = act && mdur[t] == 0;
    exp_rdy = (msp < DEPTH) && !exp_exp;
    exp_st = st_req && (!act || f_hit(st_addr, mval[t], mmask[t]));
    chk("R2 redirect", redirect, exp_exp);
    chk("R2 pc_next_out", pc_next_out, exp_exp ? mrst[t] : pc_next_in);
    chk("R6 req_ready", req_ready, exp_rdy);
    chk("R7 push_err", push_err, req_valid && msp == DEPTH);
    chk(act ? "R5 st_en" : "R4 st_en", st_en, exp_st);
    chk("R3 lease_depth", lease_depth, msp);
    chk("R1 time_left", time_left, act ? mdur[t] : 0);
    if (exp_exp) msp--;
    else if (req_valid && exp_rdy) begin
      mdur[msp] = req_dur; mrst[msp] = req_restore;
      mval[msp] = req_val; mmask[msp] = req_mask;
      msp++;
    end else if (act) mdur[t] = mdur[t] - 1'b1;
    @(negedge clk);
    cycles++;
  endtask

  task automatic drive_req(input logic v, input logic [TW-1:0] d, input logic [AW-1:0] r,
                           input logic [AW-1:0] bv, input logic [AW-1:0] bm);
    req_valid = v; req_dur = d; req_restore = r; req_val = bv; req_mask = bm;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ea5e));
    for (int i = 0; i < DEPTH; i++) begin
      mdur[i] = '0; mrst[i] = '0; mval[i] = '0; mmask[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    #1;
    chk("R9 depth", lease_depth, 0);
    chk("R9 time_left", time_left, 0);
    chk("R9 redirect", redirect, 0);
    chk("R9 req_ready", req_ready, 1);
    @(negedge clk);
    // R4: store with no lease passes
    st_req = 1; st_addr = 8'hF3; pc_next_in = 8'h10;
    step();
    // R8: zero-length lease redirects the next cycle
    drive_req(1, 0, 8'h55, 8'h00, 8'hFF);
    step();
    drive_req(0, 0, 0, 0, 0);
    #1;
    chk("R8 zero duration redirect", redirect, 1);
    chk("R8 zero duration pc", pc_next_out, 8'h55);
    step();
    // R7: fill stack, then one more request
    for (int i = 0; i < DEPTH; i++) begin
      drive_req(1, 8'd40 + 8'(i), 8'h80 + 8'(i), 8'hA0, 8'hF0);
      step();
    end
    drive_req(1, 8'd5, 8'h99, 8'h00, 8'h00);
    #1;
    chk("R7 full error", push_err, 1);
    chk("R7 full not ready", req_ready, 0);
    step();
    drive_req(0, 0, 0, 0, 0);
    // R5: inside and outside of region 1010_xxxx
    st_addr = 8'hA7; step();
    st_addr = 8'hB7; step();
    // Drain and random traffic
    for (int n = 0; n < 6000; n++) begin
      logic [AW-1:0] bv;
      bv = 8'($urandom);
      drive_req(($urandom % 4) == 0,
                ($urandom % 8 == 0) ? 8'($urandom % 60) : 8'($urandom % 5),
                8'($urandom), bv, 8'($urandom) & 8'($urandom));
      pc_next_in = 8'($urandom);
      st_req = $urandom % 2;
      st_addr = ($urandom % 2) ? (bv ^ (8'($urandom) & 8'($urandom) & 8'($urandom))) : 8'($urandom);
      step();
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule